// File: doc/BRIEF.md
# Vectored Interrupt Controller, 64 Sources

This block gathers 64 raw interrupt lines and turns them into requests on eight destinations: a normal request, a fast request and six auxiliary lines. Every source owns one control byte that holds its enable, its trigger mode and the destination it drives. Sources in edge mode keep a sticky pending bit, which software clears by writing a one to it. Sources in level mode are pending for as long as their input is high.

For the normal and the fast outputs the block also works out which pending, enabled source routed there should be serviced next. Software reads that number from a vector register. By default the lowest source number wins. When rotation is turned on, each read that returns a real source moves the starting point of the search to the next number up. When nothing is pending the vector field reads 63. Software therefore checks status bit 63 to tell a real request from source 63 apart from the idle value.

The register port is a single-cycle 32-bit bus with byte enables. It accepts every access, so there is no back-pressure. A read returns its word on the cycle after the request, marked by a valid strobe. The request outputs and the raw inputs are plain wires.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every control byte reads 0, all request outputs are low, the normal vector register (0x20) reads 0x0000003F and both status words read 0 while all inputs are low.
- R2: The control byte of source n sits at byte address 0x40+n, inside the word at 0x40+4*(n/4). Bits [2:0] hold the destination (0 normal, 1 fast, 2..7 auxiliary line 0..5), bit 3 is the enable, bit 5 selects rising edge and bit 6 selects falling edge. A write changes only the bytes whose byte enable is set.
- R3: With bits 5 and 6 both clear, a source is active-high level: its status bit equals its input, and an enabled source drives its destination output in the same cycle as the input.
- R4: In edge mode, an input transition of the selected polarity sets the source's status bit at the next clock edge, and the bit stays set after the input returns. With both bits 5 and 6 set, either transition sets it.
- R5: Status words sit at 0x80 (sources 0..31 at bit n) and 0x84 (sources 32..63 at bit n-32). Writing a one clears an edge source's status bit, writing a zero leaves it, and such a write has no effect on a level source's bit.
- R6: An edge is recorded in the status even while the source is disabled, but it drives no output until the enable bit is set.
- R7: A destination output is high exactly when at least one enabled, pending source is routed to it, and no other output is affected.
- R8: The vector registers at 0x20 (normal) and 0x24 (fast) return in bits [5:0] the number of the winning pending, enabled source routed to that output, and bit 6 returns the rotate setting. In fixed mode the lowest number wins.
- R9: With no pending, enabled source on an output, its vector field reads 63. Bit 31 of the word at 0x84 reads 1 only when source 63 is really pending.
- R10: Writing bit 6 of a vector register (byte enable 0) sets rotate mode and restarts the search at source 0. In rotate mode, a read that returns real source N makes the next search start at N+1 modulo 64.
- R11: A read request (select high, write low) is answered by rvalid high with the data on the next cycle. Addresses that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request, accepted in the same cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read |
| src_in | input | 64 | Raw interrupt inputs |
| irq_o | output | 1 | Normal request (destination 0) |
| fiq_o | output | 1 | Fast request (destination 1) |
| aux_o | output | 6 | Auxiliary requests (destinations 2..7) |

## Verification
The search is exercised with one pending source, with three pending sources at spread-out numbers (3, 10, 40), with no source pending, and with only source 63 pending. These patterns separate lowest-number selection from the rotating walk and its wrap back to 3. They also separate the idle value from a real source 63. Edge capture is driven with rising, falling and wrong-polarity transitions and with the enable off, which shows sticky capture apart from level sampling. Write-one-to-clear is tried with zero data, with ones on a level bit and with ones on an edge bit, which shows which bits a write may touch.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NUM_SRC   = 64;
  localparam int SRC_W     = $clog2(NUM_SRC);
  localparam int NUM_DEST  = 8;
  localparam int DEST_W    = $clog2(NUM_DEST);
  localparam int NUM_AUX   = NUM_DEST - 2;
  localparam int BUS_W     = 32;
  localparam int ADDR_W    = 8;
  localparam int BE_W      = BUS_W / 8;
  localparam int CTRL_WORDS = NUM_SRC / BE_W;

  // control byte fields
  localparam int CB_EN   = 3;
  localparam int CB_RISE = 5;
  localparam int CB_FALL = 6;
  localparam int VR_ROT  = 6;

  // word addresses (byte address >> 2)
  localparam logic [ADDR_W-3:0] WA_VEC_N  = 6'h08;
  localparam logic [ADDR_W-3:0] WA_VEC_F  = 6'h09;
  localparam logic [ADDR_W-3:0] WA_STAT_L = 6'h20;
  localparam logic [ADDR_W-3:0] WA_STAT_H = 6'h21;
  localparam logic [1:0]        CTRL_REGION = 2'b01;

  typedef logic [7:0] ctrl_byte_t;
endpackage

// File: rtl/irqv_src_bank.sv
module irqv_src_bank
  import irqv_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           src_i,
  input  logic                         ctl_wr_i,
  input  logic [$clog2(CTRL_WORDS)-1:0] ctl_word_i,
  input  logic [BE_W-1:0]              ctl_be_i,
  input  logic [BUS_W-1:0]             ctl_wdata_i,
  input  logic [NUM_SRC-1:0]           clr_mask_i,
  output ctrl_byte_t [NUM_SRC-1:0]     ctrl_o,
  output logic [NUM_SRC-1:0]           status_o,
  output logic [NUM_SRC-1:0]           sticky_o,
  output logic [NUM_SRC-1:0]           active_o
);
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] sticky_q;
  ctrl_byte_t [NUM_SRC-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_i;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int WIDX = i / BE_W;
    localparam int BSEL = i % BE_W;
    logic hit;
    logic is_edge;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[i] <= '0;
      else if (ctl_wr_i && ctl_word_i == WIDX[$clog2(CTRL_WORDS)-1:0] && ctl_be_i[BSEL])
        ctrl_q[i] <= ctl_wdata_i[BSEL*8 +: 8];
    end

    assign is_edge = ctrl_q[i][CB_RISE] | ctrl_q[i][CB_FALL];
    assign hit = (ctrl_q[i][CB_RISE] & src_i[i] & ~prev_q[i]) |
                 (ctrl_q[i][CB_FALL] & ~src_i[i] & prev_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             sticky_q[i] <= 1'b0;
      else if (hit)           sticky_q[i] <= 1'b1;
      else if (clr_mask_i[i]) sticky_q[i] <= 1'b0;
    end

    assign status_o[i] = is_edge ? sticky_q[i] : src_i[i];
    assign active_o[i] = status_o[i] & ctrl_q[i][CB_EN];
  end

  assign ctrl_o   = ctrl_q;
  assign sticky_o = sticky_q;
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
  parameter int N = 64,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] cand_i,
  input  logic [W-1:0] start_i,
  output logic         found_o,
  output logic [W-1:0] win_o
);
  always_comb begin
    logic [W-1:0] idx;
    found_o = 1'b0;
    win_o   = '1;
    for (int k = 0; k < N; k++) begin
      idx = start_i + W'(k);
      if (!found_o && cand_i[idx]) begin
        found_o = 1'b1;
        win_o   = idx;
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BE_W-1:0]    bus_be,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               bus_rvalid,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_o,
  output logic               fiq_o,
  output logic [NUM_AUX-1:0] aux_o
);
  localparam int NVEC = 2;
  localparam int CW_W = $clog2(CTRL_WORDS);

  logic [ADDR_W-3:0]        waddr;
  logic                     wr_acc, rd_acc, ctl_hit;
  logic [BUS_W-1:0]         be_mask;
  logic [NUM_SRC-1:0]       clr_mask;
  ctrl_byte_t [NUM_SRC-1:0] ctrl;
  logic [NUM_SRC-1:0]       status_vec, sticky_vec, active_vec, en_vec;
  logic [NUM_DEST-1:0][NUM_SRC-1:0] cand;
  logic [NUM_DEST-1:0]      req;

  logic [NVEC-1:0]            rot_q;
  logic [NVEC-1:0][SRC_W-1:0] ptr_q;
  logic [NVEC-1:0][SRC_W-1:0] win;
  logic [NVEC-1:0]            found;
  logic [BUS_W-1:0]           rd_word;

  assign waddr   = bus_addr[ADDR_W-1:2];
  assign wr_acc  = bus_sel & bus_wr;
  assign rd_acc  = bus_sel & ~bus_wr;
  assign ctl_hit = (bus_addr[ADDR_W-1:ADDR_W-2] == CTRL_REGION);

  for (genvar b = 0; b < BE_W; b++) begin : g_bem
    assign be_mask[b*8 +: 8] = {8{bus_be[b]}};
  end

  assign clr_mask[BUS_W-1:0] =
    (wr_acc && waddr == WA_STAT_L) ? (bus_wdata & be_mask) : '0;
  assign clr_mask[NUM_SRC-1:BUS_W] =
    (wr_acc && waddr == WA_STAT_H) ? (bus_wdata & be_mask) : '0;

  irqv_src_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_in),
    .ctl_wr_i   (wr_acc & ctl_hit),
    .ctl_word_i (bus_addr[CW_W+1:2]),
    .ctl_be_i   (bus_be),
    .ctl_wdata_i(bus_wdata),
    .clr_mask_i (clr_mask),
    .ctrl_o     (ctrl),
    .status_o   (status_vec),
    .sticky_o   (sticky_vec),
    .active_o   (active_vec)
  );

  // per-destination candidate sets and requests
  for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_s
      assign cand[d][i] = active_vec[i] &&
                          (ctrl[i][DEST_W-1:0] == DEST_W'(d));
    end
    assign req[d] = |cand[d];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
    assign en_vec[i] = ctrl[i][CB_EN];
  end

  assign irq_o = req[0];
  assign fiq_o = req[1];
  assign aux_o = req[NUM_DEST-1:2];

  // vector search for the two processor outputs
  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    logic [SRC_W-1:0] start;
    logic             vec_wr, vec_rd;
    assign start  = rot_q[v] ? ptr_q[v] : '0;
    assign vec_wr = wr_acc && waddr == (WA_VEC_N + (ADDR_W-2)'(v)) && bus_be[0];
    assign vec_rd = rd_acc && waddr == (WA_VEC_N + (ADDR_W-2)'(v));

    irqv_arbiter #(.N(NUM_SRC), .W(SRC_W)) u_arb (
      .cand_i (cand[v]),
      .start_i(start),
      .found_o(found[v]),
      .win_o  (win[v])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rot_q[v] <= 1'b0;
        ptr_q[v] <= '0;
      end else if (vec_wr) begin
        rot_q[v] <= bus_wdata[VR_ROT];
        ptr_q[v] <= '0;
      end else if (vec_rd && rot_q[v] && found[v]) begin
        ptr_q[v] <= win[v] + SRC_W'(1);
      end
    end
  end

  // read mux
  always_comb begin
    rd_word = '0;
    if (ctl_hit) begin
      for (int b = 0; b < BE_W; b++)
        rd_word[b*8 +: 8] = ctrl[{bus_addr[CW_W+1:2], 2'(b)}];
    end else begin
      unique case (waddr)
        WA_VEC_N:  rd_word = BUS_W'({rot_q[0], win[0]});
        WA_VEC_F:  rd_word = BUS_W'({rot_q[1], win[1]});
        WA_STAT_L: rd_word = status_vec[BUS_W-1:0];
        WA_STAT_H: rd_word = status_vec[NUM_SRC-1:BUS_W];
        default:   rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_acc;
      if (rd_acc) bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk
  import irqv_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [BUS_W-1:0]   bus_rdata,
  input logic               bus_rvalid,
  input logic               irq_o,
  input logic               fiq_o,
  input logic [NUM_AUX-1:0] aux_o,
  input logic [NUM_SRC-1:0] en_vec,
  input logic [NUM_SRC-1:0] sticky_vec
);
  p_rvalid_follows_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_sel && !bus_wr));

  p_idle_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[ADDR_W-1:2] == WA_VEC_N && !irq_o)
    |=> (bus_rdata[SRC_W-1:0] == '1));

  p_all_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec == '0) |-> (!irq_o && !fiq_o && aux_o == '0));

  p_request_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || fiq_o || aux_o != '0) |-> (en_vec != '0));

  p_sticky_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == WA_STAT_L ||
                            bus_addr[ADDR_W-1:2] == WA_STAT_H))
    |=> ((sticky_vec & $past(sticky_vec)) == $past(sticky_vec)));
endmodule

bind irq_vector_ctrl irqv_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .bus_rvalid(bus_rvalid),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .aux_o     (aux_o),
  .en_vec    (en_vec),
  .sticky_vec(sticky_vec)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [63:0] src_in = '0;
  logic        irq_o, fiq_o;
  logic [5:0]  aux_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .src_in(src_in),
    .irq_o(irq_o), .fiq_o(fiq_o), .aux_o(aux_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic drive(input int n, input logic v);
    @(negedge clk);
    src_in[n] = v;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // monitor: compare returned read data against the scoreboard queue
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R11: unexpected rvalid, got 0x%08h expected none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 outputs", {29'b0, irq_o, fiq_o, |aux_o}, 32'h0);
    rd(8'h40, 32'h0, "R1 ctrl 0x40");
    rd(8'h7C, 32'h0, "R1 ctrl 0x7C");
    rd(8'h20, 32'h3F, "R1 idle vector");
    rd(8'h84, 32'h0, "R1 status hi");

    // R2 byte-enabled control write
    wr(8'h40, 32'h2A6B190C, 4'b0101);
    rd(8'h40, 32'h006B000C, "R2 byte enables");
    wr(8'h40, 32'h0, 4'b1111);

    // R3 level source 5 to normal output
    wr(8'h44, 32'h00000800, 4'b0010);
    drive(5, 1'b1);
    #1 chk("R3 level high", {31'b0, irq_o}, 32'h1);
    rd(8'h80, 32'h20, "R3 status follows input");
    rd(8'h20, 32'h05, "R8 single winner");
    wr(8'h80, 32'h20, 4'b0001);
    rd(8'h80, 32'h20, "R5 W1C ignored on level");
    drive(5, 1'b0);
    #1 chk("R3 level low", {31'b0, irq_o}, 32'h0);

    // R4 rising edge, source 12 to fast output
    wr(8'h4C, 32'h00000029, 4'b0001);
    drive(12, 1'b1);
    @(negedge clk);
    chk("R4 rising sets", {31'b0, fiq_o}, 32'h1);
    drive(12, 1'b0);
    @(negedge clk);
    chk("R4 sticky after drop", {31'b0, fiq_o}, 32'h1);
    rd(8'h80, 32'h00001000, "R4 status sticky");
    rd(8'h24, 32'h0C, "R8 fast vector");

    // R5 write-one-to-clear
    wr(8'h80, 32'h0, 4'b1111);
    rd(8'h80, 32'h00001000, "R5 zero write keeps");
    wr(8'h80, 32'h00001000, 4'b0010);
    rd(8'h80, 32'h0, "R5 one clears");
    chk("R5 request drops", {31'b0, fiq_o}, 32'h0);

    // R4 falling edge, source 33 to aux line 0
    wr(8'h60, 32'h00004A00, 4'b0010);
    drive(33, 1'b1);
    @(negedge clk);
    chk("R4 wrong polarity ignored", {26'b0, aux_o}, 32'h0);
    drive(33, 1'b0);
    @(negedge clk);
    chk("R4 falling sets", {26'b0, aux_o}, 32'h1);
    rd(8'h84, 32'h2, "R4 status hi");
    wr(8'h84, 32'h2, 4'b0001);
    rd(8'h84, 32'h0, "R5 clear hi word");

    // R6 edge captured while disabled
    wr(8'h54, 32'h00000020, 4'b0001);
    drive(20, 1'b1);
    drive(20, 1'b0);
    @(negedge clk);
    chk("R6 disabled no request", {31'b0, irq_o}, 32'h0);
    rd(8'h80, 32'h00100000, "R6 latched while disabled");
    wr(8'h54, 32'h00000028, 4'b0001);
    chk("R6 enable raises request", {31'b0, irq_o}, 32'h1);
    wr(8'h80, 32'h00100000, 4'b0100);
    wr(8'h54, 32'h0, 4'b0001);

    // R7 routing to aux line 5
    wr(8'h68, 32'h0000000F, 4'b0001);
    drive(40, 1'b1);
    #1 chk("R7 aux5 only", {24'b0, irq_o, fiq_o, aux_o}, 32'h20);
    drive(40, 1'b0);
    #1 chk("R7 aux5 drops", {26'b0, aux_o}, 32'h0);

    // R8 fixed priority with sources 3, 10, 40 on the normal output
    wr(8'h40, 32'h08000000, 4'b1000);
    wr(8'h48, 32'h00080000, 4'b0100);
    wr(8'h68, 32'h00000008, 4'b0001);
    @(negedge clk);
    src_in[3] = 1'b1; src_in[10] = 1'b1; src_in[40] = 1'b1;
    rd(8'h20, 32'h03, "R8 lowest wins");
    rd(8'h20, 32'h03, "R8 fixed repeats");
    rd(8'h24, 32'h3F, "R9 fast idle");

    // R10 rotating priority walk and wrap
    wr(8'h20, 32'h40, 4'b0001);
    rd(8'h20, 32'h43, "R10 rotate first");
    rd(8'h20, 32'h4A, "R10 rotate second");
    rd(8'h20, 32'h68, "R10 rotate third");
    rd(8'h20, 32'h43, "R10 rotate wraps");
    rd(8'h20, 32'h4A, "R10 rotate again");
    wr(8'h20, 32'h40, 4'b0001);
    rd(8'h20, 32'h43, "R10 write restarts");
    wr(8'h20, 32'h00, 4'b0001);
    rd(8'h20, 32'h03, "R10 back to fixed");

    // R9 idle versus real source 63
    @(negedge clk);
    src_in[3] = 1'b0; src_in[10] = 1'b0; src_in[40] = 1'b0;
    rd(8'h20, 32'h3F, "R9 idle value");
    rd(8'h84, 32'h0, "R9 bit31 clear when idle");
    wr(8'h7C, 32'h08000000, 4'b1000);
    drive(63, 1'b1);
    rd(8'h20, 32'h3F, "R9 real source 63");
    rd(8'h84, 32'h80000000, "R9 bit31 set");
    chk("R9 request for 63", {31'b0, irq_o}, 32'h1);

    // R11 unmapped address
    rd(8'h10, 32'h0, "R11 unmapped");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R11: got %0d pending reads expected 0", exp_q.size());
    end
    summary();
  end
endmodule